// File: doc/BRIEF.md
# Two-Pass 32-bit Execution Unit

This block executes 32-bit register-to-register operations on hardware whose register storage, internal buses and arithmetic unit are 16 bits wide. Software sees sixteen 32-bit registers. Each one is held as a pair of 16-bit physical registers, 32 in total. A small sequencer splits every operation into passes that each touch one 16-bit half. The arithmetic carry, the low-half compare result and the bits that cross between halves during a shift are kept in small registers between passes.

An operation is issued with a one-cycle start pulse. The pulse carries an opcode, two source register numbers, a destination register number and a shift amount. The unit raises busy until the result is written, then pulses done. The carry/borrow flag and the compare flag are updated on the cycle of done and hold their values until the next operation finishes. A 16-bit host port reads and writes the physical half-registers directly, so that the surrounding pipeline can fill the register file and read results back.

Top module: `split_exec32`

## Requirements
- R1: Architectural register n (0..15) is stored as physical half-register 2n (bits 15:0) and 2n+1 (bits 31:16). The host port writes one half-register per cycle while the unit is idle and reads any half-register combinationally.
- R2: Opcode 0 (add) and opcode 1 (subtract) write the 32-bit sum or difference of srcA and srcB to dst. The low-half carry is chained into the high half. carryFlag becomes the carry out of bit 31 for add, and the borrow (srcA < srcB unsigned) for subtract.
- R3: Opcodes 2, 3 and 4 write the bitwise AND, OR and XOR of srcA and srcB to dst, and clear both flags.
- R4: The compare opcodes are 5 (equal), 6 (less-than signed), 7 (less-than unsigned), 8 (greater-or-equal signed) and 9 (greater-or-equal unsigned). Each sets cmpFlag from the full 32-bit comparison and falls back to the low halves when the high halves are equal. A compare clears carryFlag and leaves dst unchanged.
- R5: Opcodes 10 (shift left), 11 (logical shift right) and 12 (arithmetic shift right) shift srcA by shiftAmt (1..31) into dst. They run in steps of at most 4 positions, and each step takes two cycles. done rises 2*ceil(shiftAmt/4) clock edges after the edge that accepts start.
- R6: A shift with shiftAmt 0 copies srcA to dst in two cycles.
- R7: A shift with shiftAmt of 32 or more finishes in two cycles. It writes all zeros, except that an arithmetic right shift of a negative operand writes all ones.
- R8: After reset, busy, done and both flags are 0 and every register reads 0. Non-shift operations raise done two edges after the edge that accepts start. busy is high from that accepting edge until done rises. done is high for exactly one cycle, with busy low.
- R9: A start pulse received while busy is ignored. The running operation completes unchanged, and no second result, done pulse or register write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue pulse, accepted only when idle |
| opcode | input | 4 | Operation code, see R2..R5 |
| srcA | input | 4 | First source architectural register |
| srcB | input | 4 | Second source architectural register |
| dst | input | 4 | Destination architectural register |
| shiftAmt | input | 6 | Shift amount 0..63 |
| hostWrEn | input | 1 | Host half-register write enable |
| hostWrIdx | input | 5 | Host write physical index |
| hostWrData | input | 16 | Host write data |
| hostRdIdx | input | 5 | Host read physical index |
| hostRdData | output | 16 | Host read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carryFlag | output | 1 | Carry (add) or borrow (subtract) |
| cmpFlag | output | 1 | Compare result |

## Verification
The arithmetic operands are chosen so that the answer depends on the chained carry. They include a low half of all ones that must ripple into the high half, and a wrap of all ones plus one that must produce carry out and a zero result. Compares use operand pairs whose high halves differ in sign only, which separates signed from unsigned ordering. Other pairs have equal high halves, so only the low-half fallback decides them. Shift amounts 0, 1, 4, 5, 13, 17, 31, 32, 40 and 63 separate a single partial step from whole steps, from steps that move bits across the half boundary, and from the fill path. Each shift is checked for both value and latency. A start pulse is also injected in the middle of a running operation to show that it leaves no trace.

// File: rtl/split_exec32_pkg.sv
package split_exec32_pkg;
  localparam int HALF_W   = 16;
  localparam int NUM_ARCH = 16;
  localparam int PHYS_N   = 2 * NUM_ARCH;
  localparam int AIDX_W   = $clog2(NUM_ARCH);
  localparam int PIDX_W   = AIDX_W + 1;
  localparam int AMT_W    = 6;
  localparam int STEP_MAX = 4;
  localparam int HOLD_W   = STEP_MAX;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int FULL_AMT = 2 * HALF_W;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CEQ  = 4'd5,
    OP_CLT  = 4'd6,
    OP_CLTU = 4'd7,
    OP_CGE  = 4'd8,
    OP_CGEU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12
  } opcode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              capture;   // latch operands of a new operation
    logic              active;    // a pass runs this cycle
    logic              hiHalf;    // pass works on bits 31:16
    logic              fromDst;   // later shift steps read the destination
    logic              lastPass;  // final pass: update flags
    logic              fill;      // shift amount of FULL_AMT or more
    logic [STEP_W-1:0] step;      // shift distance of this step
  } strobe_t;

  function automatic logic isShiftOp(input logic [3:0] op);
    return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
  endfunction

  function automatic logic isCmpOp(input logic [3:0] op);
    return (op >= OP_CEQ) && (op <= OP_CGEU);
  endfunction
endpackage

// File: rtl/split_exec32_seq.sv
module split_exec32_seq
  import split_exec32_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       opIn,
  input  logic [AMT_W-1:0] amtIn,
  output strobe_t          strobe,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_PASS_A, ST_PASS_B} state_e;

  state_e           state;
  logic [3:0]       opQ;
  logic [AMT_W-1:0] remQ;
  logic             fillQ;
  logic             firstQ;

  logic              shiftOp, rightOp, lastStep;
  logic [STEP_W-1:0] stepAmt;
  logic [AMT_W-1:0]  remAfter;

  always_comb begin
    shiftOp  = isShiftOp(opQ);
    rightOp  = (opQ == OP_SRL) || (opQ == OP_SRA);
    if (shiftOp && !fillQ)
      stepAmt = (remQ > AMT_W'(STEP_MAX)) ? STEP_W'(STEP_MAX) : STEP_W'(remQ);
    else
      stepAmt = '0;
    remAfter = remQ - AMT_W'(stepAmt);
    lastStep = !shiftOp || fillQ || (remAfter == '0);

    strobe.capture  = (state == ST_IDLE) && start;
    strobe.active   = (state != ST_IDLE);
    // right shifts move bits downward, so the upper half goes first
    strobe.hiHalf   = (state == ST_PASS_A) ? rightOp : !rightOp;
    strobe.fromDst  = !firstQ;
    strobe.lastPass = (state == ST_PASS_B) && lastStep;
    strobe.fill     = fillQ;
    strobe.step     = stepAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opQ    <= '0;
      remQ   <= '0;
      fillQ  <= 1'b0;
      firstQ <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            opQ    <= opIn;
            fillQ  <= (amtIn >= AMT_W'(FULL_AMT));
            remQ   <= (amtIn >= AMT_W'(FULL_AMT)) ? '0 : amtIn;
            firstQ <= 1'b1;
            busy   <= 1'b1;
            state  <= ST_PASS_A;
          end
        end
        ST_PASS_A: state <= ST_PASS_B;
        ST_PASS_B: begin
          if (lastStep) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            remQ   <= remAfter;
            firstQ <= 1'b0;
            state  <= ST_PASS_A;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (opQ == $past(opQ)));
  // R5
  step_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS_B && !lastStep) |=> (remQ < $past(remQ)));
  // R8
  pass_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS_A) |=> (state == ST_PASS_B));
endmodule

// File: rtl/split_exec32_path.sv
module split_exec32_path
  import split_exec32_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [3:0]        opIn,
  input  logic [AIDX_W-1:0] srcAIn,
  input  logic [AIDX_W-1:0] srcBIn,
  input  logic [AIDX_W-1:0] dstIn,
  input  logic              hostWrEn,
  input  logic [PIDX_W-1:0] hostWrIdx,
  input  logic [HALF_W-1:0] hostWrData,
  input  logic [PIDX_W-1:0] hostRdIdx,
  output logic [HALF_W-1:0] hostRdData,
  output logic              carryFlag,
  output logic              cmpFlag
);
  localparam int WIDE_W = HALF_W + HOLD_W;

  logic [HALF_W-1:0] rf [PHYS_N];
  logic [3:0]        opQ;
  logic [AIDX_W-1:0] aQ, bQ, dQ;
  logic              carryQ, eqLoQ, ltLoQ, signQ;
  logic [HOLD_W-1:0] holdQ;

  logic [PIDX_W-1:0] aIdx, bIdx, wIdx;
  logic [HALF_W-1:0] aV, bV, bX, res;
  logic [HALF_W:0]   sum;
  logic              subLike, cin, eqH, ltU, ltS, ltFinS, ltFinU, eqFin, signBit;
  logic              cmpOp, shiftOp, doWrite, newCarry, newCmp;
  logic [WIDE_W-1:0] shl, shrL, shrA, shr;
  logic [HOLD_W-1:0] newHold;

  assign hostRdData = rf[hostRdIdx];

  always_comb begin
    cmpOp   = isCmpOp(opQ);
    shiftOp = isShiftOp(opQ);
    aIdx    = {(strobe.fromDst ? dQ : aQ), strobe.hiHalf};
    bIdx    = {bQ, strobe.hiHalf};
    wIdx    = {dQ, strobe.hiHalf};
    aV      = rf[aIdx];
    bV      = rf[bIdx];

    subLike = (opQ == OP_SUB) || cmpOp;
    bX      = subLike ? ~bV : bV;
    cin     = strobe.hiHalf ? carryQ : subLike;
    sum     = {1'b0, aV} + {1'b0, bX} + {{HALF_W{1'b0}}, cin};

    eqH    = (aV == bV);
    ltU    = (aV < bV);
    ltS    = ($signed(aV) < $signed(bV));
    ltFinS = eqH ? ltLoQ : ltS;
    ltFinU = eqH ? ltLoQ : ltU;
    eqFin  = eqH && eqLoQ;

    shl  = {{HOLD_W{1'b0}}, aV} << strobe.step;
    shrL = {aV, {HOLD_W{1'b0}}} >> strobe.step;
    shrA = $unsigned($signed({aV, {HOLD_W{1'b0}}}) >>> strobe.step);
    // only the upper half carries the sign
    shr  = (opQ == OP_SRA && strobe.hiHalf) ? shrA : shrL;
    signBit = strobe.hiHalf ? aV[HALF_W-1] : signQ;

    newHold = '0;
    res     = '0;
    unique case (opQ)
      OP_ADD, OP_SUB: res = sum[HALF_W-1:0];
      OP_AND: res = aV & bV;
      OP_OR:  res = aV | bV;
      OP_XOR: res = aV ^ bV;
      OP_SLL: begin
        newHold = shl[WIDE_W-1:HALF_W];
        res     = shl[HALF_W-1:0] |
                  (strobe.hiHalf ? {{(HALF_W-HOLD_W){1'b0}}, holdQ} : '0);
      end
      OP_SRL, OP_SRA: begin
        newHold = shr[HOLD_W-1:0];
        res     = shr[WIDE_W-1:HOLD_W] |
                  (strobe.hiHalf ? '0 : {holdQ, {(HALF_W-HOLD_W){1'b0}}});
      end
      default: res = '0;
    endcase
    if (shiftOp && strobe.fill)
      res = (opQ == OP_SRA && signBit) ? '1 : '0;

    doWrite = strobe.active && !cmpOp;

    newCarry = 1'b0;
    if (opQ == OP_ADD) newCarry = sum[HALF_W];
    if (opQ == OP_SUB) newCarry = !sum[HALF_W];

    unique case (opQ)
      OP_CEQ:  newCmp = eqFin;
      OP_CLT:  newCmp = ltFinS;
      OP_CLTU: newCmp = ltFinU;
      OP_CGE:  newCmp = !ltFinS;
      OP_CGEU: newCmp = !ltFinU;
      default: newCmp = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_N; i++) rf[i] <= '0;
      opQ       <= '0;
      aQ        <= '0;
      bQ        <= '0;
      dQ        <= '0;
      carryQ    <= 1'b0;
      eqLoQ     <= 1'b0;
      ltLoQ     <= 1'b0;
      signQ     <= 1'b0;
      holdQ     <= '0;
      carryFlag <= 1'b0;
      cmpFlag   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        opQ <= opIn;
        aQ  <= srcAIn;
        bQ  <= srcBIn;
        dQ  <= dstIn;
      end
      if (strobe.active) begin
        carryQ <= sum[HALF_W];
        holdQ  <= newHold;
        if (strobe.hiHalf) signQ <= aV[HALF_W-1];
        else begin
          eqLoQ <= eqH;
          ltLoQ <= ltU;
        end
      end
      if (doWrite) rf[wIdx] <= res;
      else if (hostWrEn && !strobe.active) rf[hostWrIdx] <= hostWrData;
      if (strobe.lastPass) begin
        carryFlag <= newCarry;
        cmpFlag   <= newCmp;
      end
    end
  end

  // R6
  zero_step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && shiftOp && !strobe.fill && strobe.step == '0) |=> (holdQ == '0));
  // R4
  cmp_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lastPass && cmpOp) |=> !carryFlag);
endmodule

// File: rtl/split_exec32.sv
module split_exec32
  import split_exec32_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        opcode,
  input  logic [AIDX_W-1:0] srcA,
  input  logic [AIDX_W-1:0] srcB,
  input  logic [AIDX_W-1:0] dst,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              hostWrEn,
  input  logic [PIDX_W-1:0] hostWrIdx,
  input  logic [HALF_W-1:0] hostWrData,
  input  logic [PIDX_W-1:0] hostRdIdx,
  output logic [HALF_W-1:0] hostRdData,
  output logic              busy,
  output logic              done,
  output logic              carryFlag,
  output logic              cmpFlag
);
  strobe_t strobe;

  split_exec32_seq uSeq (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opcode), .amtIn(shiftAmt),
    .strobe(strobe), .busy(busy), .done(done)
  );

  split_exec32_path uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(opcode),
    .srcAIn(srcA), .srcBIn(srcB), .dstIn(dst),
    .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx), .hostWrData(hostWrData),
    .hostRdIdx(hostRdIdx), .hostRdData(hostRdData),
    .carryFlag(carryFlag), .cmpFlag(cmpFlag)
  );
endmodule

// File: tb/tb_split_exec32.sv
module tb_split_exec32;
  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [3:0]  opcode, srcA, srcB, dst;
  logic [5:0]  shiftAmt;
  logic        hostWrEn;
  logic [4:0]  hostWrIdx, hostRdIdx;
  logic [15:0] hostWrData, hostRdData;
  logic        busy, done, carryFlag, cmpFlag;

  always #5 clk = ~clk;

  split_exec32 dut (.*);

  typedef struct {
    int          d;
    logic [31:0] val;
    logic        c;
    logic        t;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] model [16];
  int          checks = 0, fails = 0;
  int          edgeCnt = 0, startMark = 0;
  bit          finished = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input int n, output logic [31:0] v);
    hostRdIdx = 5'(2*n);     #1; v[15:0]  = hostRdData;
    hostRdIdx = 5'(2*n + 1); #1; v[31:16] = hostRdData;
  endtask

  task automatic setReg(input int n, input logic [31:0] v);
    @(negedge clk);
    hostWrEn = 1; hostWrIdx = 5'(2*n); hostWrData = v[15:0];
    @(negedge clk);
    hostWrIdx = 5'(2*n + 1); hostWrData = v[31:16];
    @(negedge clk);
    hostWrEn = 0;
    model[n] = v;
  endtask

  // driver: compute expectation, push, issue, wait for completion
  task automatic runOp(input int op, input int a, input int b, input int d,
                       input int amt, input string tag, input bit intrude);
    exp_t e;
    logic [31:0] x, y, r;
    logic [32:0] w;
    logic c, t;
    bit   isCmp;
    int   lat;
    x = model[a]; y = model[b]; r = model[d]; c = 0; t = 0; isCmp = 0; lat = 2;
    case (op)
      0: begin w = {1'b0, x} + {1'b0, y}; r = w[31:0]; c = w[32]; end
      1: begin r = x - y; c = (x < y); end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: begin isCmp = 1; t = (x == y); end
      6: begin isCmp = 1; t = ($signed(x) < $signed(y)); end
      7: begin isCmp = 1; t = (x < y); end
      8: begin isCmp = 1; t = ($signed(x) >= $signed(y)); end
      9: begin isCmp = 1; t = (x >= y); end
      10: r = (amt >= 32) ? 32'h0 : x << amt;
      11: r = (amt >= 32) ? 32'h0 : x >> amt;
      12: r = $unsigned($signed(x) >>> amt);
      default: ;
    endcase
    if (op >= 10 && amt > 0 && amt < 32) lat = 2 * ((amt + 3) / 4);
    e.d = d; e.val = r; e.c = c; e.t = t; e.lat = lat; e.tag = tag;
    sbq.push_back(e);
    if (!isCmp) model[d] = r;
    @(negedge clk);
    start = 1; opcode = 4'(op); srcA = 4'(a); srcB = 4'(b); dst = 4'(d);
    shiftAmt = 6'(amt); startMark = edgeCnt;
    @(negedge clk);
    start = 0;
    if (intrude) begin
      // R9: a second issue while busy, writing to register 14
      start = 1; opcode = 4'd3; srcA = 4'd3; srcB = 4'd3; dst = 4'd14; shiftAmt = 0;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare on each completion
  always @(negedge clk) begin
    if (rstN && done) begin
      exp_t e;
      logic [31:0] v;
      int lat;
      lat = edgeCnt - startMark - 1;
      if (sbq.size() == 0) begin
        check(0, "R9 unexpected done", 32'h1, 32'h0);
      end else begin
        e = sbq.pop_front();
        readReg(e.d, v);
        check(v == e.val, {e.tag, " value"}, v, e.val);
        check(carryFlag == e.c, {e.tag, " carryFlag"}, 32'(carryFlag), 32'(e.c));
        check(cmpFlag == e.t, {e.tag, " cmpFlag"}, 32'(cmpFlag), 32'(e.t));
        check(lat == e.lat, {e.tag, " latency"}, 32'(lat), 32'(e.lat));
        check(!busy, {e.tag, " R8 busy low at done"}, 32'(busy), 32'h0);
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    logic [31:0] v;
    rstN = 0; start = 0; opcode = 0; srcA = 0; srcB = 0; dst = 0; shiftAmt = 0;
    hostWrEn = 0; hostWrIdx = 0; hostWrData = 0; hostRdIdx = 0;
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    check(!busy, "R8 reset busy", 32'(busy), 0);
    check(!done, "R8 reset done", 32'(done), 0);
    check(!carryFlag && !cmpFlag, "R8 reset flags", {30'h0, carryFlag, cmpFlag}, 0);
    readReg(5, v);
    check(v == 0, "R8 reset register", v, 0);

    setReg(1, 32'h0001FFFF);
    setReg(2, 32'h00000001);
    setReg(3, 32'hFFFFFFFF);
    setReg(4, 32'h80000000);
    setReg(5, 32'h12345678);
    setReg(6, 32'h12340000);
    setReg(11, 32'h8000F00F);
    // R1 half placement
    hostRdIdx = 5'd11; #1;
    check(hostRdData == 16'h1234, "R1 high half index", 32'(hostRdData), 32'h1234);
    hostRdIdx = 5'd10; #1;
    check(hostRdData == 16'h5678, "R1 low half index", 32'(hostRdData), 32'h5678);

    runOp(0, 1, 2, 7, 0, "R2 add carry chain", 0);
    runOp(0, 3, 2, 8, 0, "R2 add wrap carry", 0);
    runOp(1, 2, 3, 9, 0, "R2 sub borrow", 0);
    runOp(1, 1, 2, 10, 0, "R2 sub no borrow", 0);
    runOp(2, 5, 6, 12, 0, "R3 and", 0);
    runOp(3, 5, 4, 12, 0, "R3 or", 0);
    runOp(4, 5, 6, 12, 0, "R3 xor", 0);
    runOp(5, 5, 5, 5, 0, "R4 equal", 0);
    runOp(5, 5, 6, 5, 0, "R4 not equal", 0);
    runOp(6, 4, 2, 5, 0, "R4 lt signed", 0);
    runOp(7, 4, 2, 5, 0, "R4 lt unsigned", 0);
    runOp(6, 6, 5, 5, 0, "R4 lt fallback low", 0);
    runOp(8, 5, 6, 5, 0, "R4 ge signed fallback", 0);
    runOp(9, 6, 5, 5, 0, "R4 ge unsigned", 0);
    runOp(8, 2, 4, 5, 0, "R4 ge signed sign", 0);
    runOp(10, 5, 0, 13, 0, "R6 shift zero", 0);
    runOp(10, 5, 0, 13, 1, "R5 sll 1", 0);
    runOp(10, 5, 0, 13, 4, "R5 sll 4", 0);
    runOp(10, 5, 0, 13, 5, "R5 sll 5", 0);
    runOp(10, 5, 0, 13, 13, "R5 sll 13", 0);
    runOp(10, 3, 0, 13, 31, "R5 sll 31", 0);
    runOp(10, 5, 0, 13, 32, "R7 sll 32", 0);
    runOp(11, 4, 0, 13, 3, "R5 srl 3", 0);
    runOp(11, 11, 0, 13, 17, "R5 srl 17", 0);
    runOp(12, 11, 0, 13, 7, "R5 sra 7", 0);
    runOp(12, 11, 0, 13, 31, "R5 sra 31", 0);
    runOp(12, 11, 0, 13, 40, "R7 sra fill ones", 0);
    runOp(12, 5, 0, 13, 63, "R7 sra fill zeros", 0);
    runOp(11, 3, 0, 13, 40, "R7 srl 40", 0);
    runOp(12, 11, 0, 11, 5, "R5 sra in place", 0);
    runOp(0, 5, 6, 15, 0, "R9 running op", 1);
    readReg(14, v);
    check(v == model[14], "R9 intruding op wrote nothing", v, model[14]);
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R9 scoreboard drained", 32'(sbq.size()), 0);
    summary();
  end
endmodule